// File: doc/BRIEF.md
# Two-Wire Bus Start Detector with Clock Hold

This block sits on the two wires of a serial bus, a clock line and a data line, and recognises the start of a bus transaction: a high-to-low transition on the data line while the clock line is high. The transition is captured by a storage element clocked by the data line itself, not by the system clock. The captured state drives a wake request at once, so a sleeping core can be woken by bus traffic. Detection only happens when the two-wire mode input is asserted.

The data line passes through a short delay before the comparison, so the clock line is still settled when it is sampled. The delay is a configurable number of system-clock cycles. The captured start goes through a synchroniser into the clocked domain as a sticky start flag. When the flag rises, the block pulls the bus clock low and stretches the transfer. The pull stays on until the local logic asserts a release, clears the flag, or leaves two-wire mode. The bus clock may run at up to one quarter of the system clock.

Top module: `twsd_start_hold`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge), wake_req, start_flag and scl_hold are all 0.
- R2: With tw_mode=1, a falling sda_in while scl_in=1 raises wake_req. This happens DLY_CYC clock edges after the fall is first sampled, and needs no further clock edge once the delayed data line has fallen.
- R3: A falling sda_in while scl_in=0 is ignored: wake_req, start_flag and scl_hold stay 0.
- R4: With tw_mode=0, no sda_in fall sets wake_req or start_flag, and scl_hold is forced to 0 on the next edge.
- R5: start_flag follows wake_req through a SYNC_DEPTH-flop synchroniser (2 flops by default). It rises two edges after wake_req rises.
- R6: The start state is sticky. A 1 on flag_clr at a clock edge drops wake_req by the next edge, and start_flag follows through the synchroniser.
- R7: scl_hold (1 means the bus clock line is pulled low) goes to 1 on the edge after start_flag rises.
- R8: A 1 on hold_release at an edge drops scl_hold on that edge and leaves start_flag set.
- R9: A 1 on flag_clr at an edge also drops scl_hold on that edge.
- R10: A rising sda_in while scl_in=1 (a stop condition) does not set wake_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also clears the captured start |
| tw_mode | input | 1 | 1 enables two-wire start detection and clock hold |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| flag_clr | input | 1 | Write-one clear of the start state; also ends the hold |
| hold_release | input | 1 | Ends the bus clock hold without clearing the flag |
| start_flag | output | 1 | Sticky, synchronised start indication |
| wake_req | output | 1 | Unsynchronised start indication for wake-up |
| scl_hold | output | 1 | 1 drives the open-drain pull-down on the bus clock line |

## Verification
The assertions check on every cycle how the wake request, the synchronised flag and the hold relate to one another. A flag rise needs a wake request two edges earlier. A hold rise needs a set flag. Release, clear and mode exit each end the hold on the next edge, and a clear removes the wake request. Only the bench scenarios show that a start needs the clock line high at the delayed data fall. They also show that falls with the clock low, stop conditions and falls outside two-wire mode are ignored, and that the delay is exactly DLY_CYC edges.

// File: rtl/twsd_pkg.sv
// Shared definitions for the two-wire start detector.
// Assumes nothing beyond a single system clock domain for the clocked part.
package twsd_pkg;
    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam int unsigned DLY_CYC_DEF    = 2;

    typedef enum logic {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_e;
endpackage

// File: rtl/twsd_sda_delay.sv
// Delays the bus data line by DLY_CYC system-clock cycles so the clock line
// is settled when the capture element samples it.
// Assumes DLY_CYC >= 1; the line idles high, so reset loads ones.
module twsd_sda_delay #(
    parameter int unsigned DLY_CYC = twsd_pkg::DLY_CYC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    output logic sda_dly
);
    generate
        if (DLY_CYC == 1) begin : g_single
            logic stage_q;
            // Single-stage delay register.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b1;
                else        stage_q <= sda_in;
            end
            assign sda_dly = stage_q;
        end else begin : g_chain
            logic [DLY_CYC-1:0] chain_q;
            // Shift the data line along the delay chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[DLY_CYC-2:0], sda_in};
            end
            assign sda_dly = chain_q[DLY_CYC-1];
        end
    endgenerate
endmodule

// File: rtl/twsd_start_latch.sv
// Captures a start condition: it is clocked by the falling edge of the delayed
// data line and loads 1 when two-wire mode is on and the clock line is high.
// It needs no system clock, so its output can serve as a wake request.
// Assumes kill is a clean (registered or reset) level.
module twsd_start_latch (
    input  logic sda_fall_clk,
    input  logic kill,
    input  logic mode_on,
    input  logic scl_lvl,
    output logic captured
);
    logic cap_q;

    // Set on a qualified data fall; cleared asynchronously by kill.
    always_ff @(negedge sda_fall_clk or posedge kill) begin
        if (kill)                    cap_q <= 1'b0;
        else if (mode_on && scl_lvl) cap_q <= 1'b1;
    end

    assign captured = cap_q;
endmodule

// File: rtl/twsd_sync.sv
// Multi-flop synchroniser that brings an asynchronous level into clk.
// Assumes STAGES >= 2.
module twsd_sync #(
    parameter int unsigned STAGES = twsd_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] ff_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= {ff_q[STAGES-2:0], async_in};
    end

    assign sync_out = ff_q[STAGES-1];
endmodule

// File: rtl/twsd_start_hold.sv
// Top of the two-wire start detector: delays the data line, captures start
// conditions without the system clock, synchronises the result into a sticky
// flag and holds the bus clock low after each new start until released.
// Assumes scl_in/sda_in run at most at a quarter of the clk frequency.
module twsd_start_hold #(
    parameter int unsigned DLY_CYC    = twsd_pkg::DLY_CYC_DEF,
    parameter int unsigned SYNC_DEPTH = twsd_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tw_mode,
    input  logic scl_in,
    input  logic sda_in,
    input  logic flag_clr,
    input  logic hold_release,
    output logic start_flag,
    output logic wake_req,
    output logic scl_hold
);
    import twsd_pkg::*;

    logic  sda_dly;
    logic  clr_q;
    logic  cap_kill;
    logic  cap_raw;
    logic  flag_sync;
    logic  flag_prev_q;
    hold_e hold_q;

    twsd_sda_delay #(.DLY_CYC(DLY_CYC)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_in  (sda_in),
        .sda_dly (sda_dly)
    );

    // Register the clear request so the capture element sees a clean kill.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= flag_clr;
    end

    assign cap_kill = clr_q | ~rst_n;

    twsd_start_latch u_cap (
        .sda_fall_clk (sda_dly),
        .kill         (cap_kill),
        .mode_on      (tw_mode),
        .scl_lvl      (scl_in),
        .captured     (cap_raw)
    );

    twsd_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_raw),
        .sync_out (flag_sync)
    );

    // Remember the previous synchronised flag for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_prev_q <= 1'b0;
        else        flag_prev_q <= flag_sync;
    end

    // Clock-hold control: a new start engages, release/clear/mode exit end it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 hold_q <= HOLD_OFF;
        else if (!tw_mode || hold_release || flag_clr) hold_q <= HOLD_OFF;
        else if (flag_sync && !flag_prev_q)         hold_q <= HOLD_ON;
    end

    assign wake_req   = cap_raw;
    assign start_flag = flag_sync;
    assign scl_hold   = (hold_q == HOLD_ON);
endmodule

// File: rtl/twsd_start_hold_chk.sv
// Checker for twsd_start_hold: relates wake, flag and hold over time.
// Assumes the default synchroniser depth of two flops.
module twsd_start_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic tw_mode,
    input logic flag_clr,
    input logic hold_release,
    input logic start_flag,
    input logic wake_req,
    input logic scl_hold
);
    // R5
    flag_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(wake_req, 2));

    // R7
    hold_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(start_flag));

    // R8
    release_ends_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |=> !scl_hold);

    // R9
    clear_ends_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !scl_hold);

    // R6
    clear_drops_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !wake_req);

    // R4
    mode_off_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tw_mode |=> !scl_hold);
endmodule

bind twsd_start_hold twsd_start_hold_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tw_mode      (tw_mode),
    .flag_clr     (flag_clr),
    .hold_release (hold_release),
    .start_flag   (start_flag),
    .wake_req     (wake_req),
    .scl_hold     (scl_hold)
);

// File: tb/twsd_start_hold_bench.sv
module twsd_start_hold_bench;
    localparam int unsigned DLY        = 2;
    localparam time         CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tw_mode = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic flag_clr = 1'b0;
    logic hold_release = 1'b0;
    logic start_flag, wake_req, scl_hold;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twsd_start_hold u_twsd_start_hold (
        .clk(clk), .rst_n(rst_n), .tw_mode(tw_mode), .scl_in(scl_in),
        .sda_in(sda_in), .flag_clr(flag_clr), .hold_release(hold_release),
        .start_flag(start_flag), .wake_req(wake_req), .scl_hold(scl_hold)
    );

    // Behavioural reference model, advanced on every rising edge.
    bit hist[$];
    bit m_dly = 1'b1, m_raw = 1'b0, m_clr = 1'b0;
    bit m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0, m_hold = 1'b0;

    always @(posedge clk) begin
        bit n_dly, n_clr, n_s1, n_s2, n_prev, n_hold;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < DLY; i++) hist.push_back(1'b1);
            m_dly = 1'b1; m_raw = 1'b0; m_clr = 1'b0;
            m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0; m_hold = 1'b0;
        end else begin
            hist.push_front(sda_in);
            void'(hist.pop_back());
            n_dly  = hist[DLY-1];
            n_clr  = flag_clr;
            n_s1   = m_raw;
            n_s2   = m_s1;
            n_prev = m_s2;
            if (!tw_mode || hold_release || flag_clr) n_hold = 1'b0;
            else if (m_s2 && !m_prev)                n_hold = 1'b1;
            else                                     n_hold = m_hold;
            if (n_clr) m_raw = 1'b0;
            else if (m_dly && !n_dly && tw_mode && scl_in) m_raw = 1'b1;
            m_dly = n_dly; m_clr = n_clr;
            m_s1 = n_s1; m_s2 = n_s2; m_prev = n_prev; m_hold = n_hold;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model wake_req", wake_req, m_raw);
            chk("R5 model start_flag", start_flag, m_s2);
            chk("R7 model scl_hold", scl_hold, m_hold);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        step(3);
        chk("R1 wake_req", wake_req, 1'b0);
        chk("R1 start_flag", start_flag, 1'b0);
        chk("R1 scl_hold", scl_hold, 1'b0);
        rst_n = 1'b1; tw_mode = 1'b1;
        step(4);

        // R2/R5/R7: start with the clock line high
        sda_in = 1'b0;
        step(1); chk("R2 wake before delay", wake_req, 1'b0);
        step(1); chk("R2 wake after delay", wake_req, 1'b1);
        step(1); chk("R5 flag not yet", start_flag, 1'b0);
        step(1); chk("R5 flag synced", start_flag, 1'b1);
        chk("R7 hold not yet", scl_hold, 1'b0);
        step(1); chk("R7 hold engaged", scl_hold, 1'b1);
        scl_in = 1'b0; step(2); sda_in = 1'b1; step(3);
        chk("R7 hold kept", scl_hold, 1'b1);

        // R8: release drops the hold, flag stays
        hold_release = 1'b1; step(1); hold_release = 1'b0;
        chk("R8 hold released", scl_hold, 1'b0);
        chk("R8 flag kept", start_flag, 1'b1);
        step(2);

        // R6: clear drops wake then flag
        pulse_clr();
        chk("R6 wake cleared", wake_req, 1'b0);
        step(3);
        chk("R6 flag cleared", start_flag, 1'b0);

        // R3: data fall with the clock line low
        sda_in = 1'b0; step(6);
        chk("R3 wake ignored", wake_req, 1'b0);
        chk("R3 flag ignored", start_flag, 1'b0);
        chk("R3 hold ignored", scl_hold, 1'b0);

        // R10: data rise with the clock line high
        scl_in = 1'b1; step(2); sda_in = 1'b1; step(6);
        chk("R10 stop ignored", wake_req, 1'b0);
        chk("R10 flag ignored", start_flag, 1'b0);

        // R4: start pattern outside two-wire mode
        tw_mode = 1'b0; step(1);
        sda_in = 1'b0; step(6);
        chk("R4 wake off-mode", wake_req, 1'b0);
        chk("R4 flag off-mode", start_flag, 1'b0);
        sda_in = 1'b1; step(4);
        tw_mode = 1'b1; step(2);

        // R9: clear during a hold
        sda_in = 1'b0; step(5);
        chk("R9 hold engaged", scl_hold, 1'b1);
        scl_in = 1'b0; step(2);
        pulse_clr();
        chk("R9 hold cleared", scl_hold, 1'b0);
        step(3);
        chk("R9 flag cleared", start_flag, 1'b0);
        sda_in = 1'b1; step(3); scl_in = 1'b1; step(3);

        // R4: leaving the mode ends a hold
        sda_in = 1'b0; step(5);
        chk("R4 hold before exit", scl_hold, 1'b1);
        tw_mode = 1'b0; step(1);
        chk("R4 hold after exit", scl_hold, 1'b0);
        step(2);

        done = 1'b1;
        summary();
    end
endmodule